// File: doc/BRIEF.md
# Variable-Length Code Bus Packer

This block takes a stream of variable-length codes, each from 1 to 32 bits long, and lays them end to end on a 32-bit output bus. No bit lanes are left idle. Each code goes into the lowest free bit positions of the word being built. A code that runs past bit 31 is cut in two: its low part finishes the current word, and its high part starts at bit 0 of the next word. Completed words leave through a valid/ready output port. Codes enter through a valid/ready input port, at most one code per cycle.

A compressed program is made of independently decodable blocks. At the end of a block, a flush request closes the stream. Any bits still pending are padded with zeros up to a whole word and sent, so the next block starts on a fresh word boundary. Inside, the packer keeps a two-word accumulator and a fill count. It takes a new code only when that code is sure to fit.

Top module: `bitPacker`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: Codes are placed in arrival order into consecutive bit positions, filling each word from bit 0 upward. The first code of a stream starts at bit 0, and its bit 0 lands at output bit 0.
- R3: A code that does not fit in the rest of the current word is split. Its remaining high bits continue at bit 0 of the next word. The packer never holds more than 64 pending bits.
- R4: Only the low `inLen` bits of `inCode` are used, and the bits above them have no effect on the output. A length value from 33 to 63 is treated as 32. A length of 0 completes the handshake and adds no bits.
- R5: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outWord` holds its value.
- R6: `inReady` is 1 when no flush is pending and either at most 32 bits are held or `outReady` is 1. Otherwise it is 0.
- R7: A flush request zero-pads the pending bits to a whole word. The packer first sends every remaining full word, then the padded word. Codes that come after the flush start at bit 0 of a new word. A code accepted in the same cycle as the flush request belongs before the flush. `outValid` is 1 exactly when a full word or a padded flush word is waiting.
- R8: A flush request when no bits are held sends no word. A flush request made while a flush is still pending is ignored. While a flush is pending, `inReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A code is offered |
| inReady | output | 1 | Packer takes the offered code this cycle |
| inCode | input | 32 | Code bits, LSB first |
| inLen | input | 6 | Code length in bits (1 to 32) |
| flushReq | input | 1 | Close the current block, pad and send the partial word |
| outValid | output | 1 | A packed word is available |
| outReady | input | 1 | Consumer takes the word this cycle |
| outWord | output | 32 | Packed bus word |

## Verification
Two sets of events can fall in the same clock edge. First, a full word can leave while a new code is taken, and the new code may be split across the word that remains. Second, a flush request can arrive in the same cycle as the last code of a block. The random phase drives `outReady` high most of the time, offers codes nearly every cycle and raises flush now and then, so both coincidences happen many times. A behavioural bit-queue model in the bench pops 32 bits per output handshake, pushes the accepted code, and then pads on a flush. On every clock it predicts `inReady`, `outValid` and `outWord`, and any mismatch in the order of the two events shows up at once.

// File: rtl/packPkg.sv
package packPkg;
  localparam int DEF_WORD_W = 32;
  localparam int DEF_LEN_W  = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // append the offered code
    logic shiftWord;   // a full low word leaves: shift down one word
    logic dropPartial; // padded flush word leaves: clear everything
  } ctrlStrobe_t;
endpackage

// File: rtl/packData.sv
module packData
  import packPkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int LEN_W  = DEF_LEN_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [WORD_W-1:0]          inCode,
  input  logic [LEN_W-1:0]           inLen,
  output logic [2*WORD_W-1:0]        accBits,
  output logic [$clog2(2*WORD_W+1)-1:0] fillCnt
);
  localparam int ACC_W  = 2 * WORD_W;
  localparam int FILL_W = $clog2(ACC_W + 1);

  logic [FILL_W-1:0] effLen;
  logic [WORD_W-1:0] maskedCode;
  logic [ACC_W-1:0]  baseBits, accNext;
  logic [FILL_W-1:0] baseFill, fillNext;

  // saturate the length at one word
  always_comb begin
    if (FILL_W'(inLen) > FILL_W'(WORD_W)) effLen = FILL_W'(WORD_W);
    else                                  effLen = FILL_W'(inLen);
  end

  // keep only the low effLen bits of the code
  for (genvar b = 0; b < WORD_W; b++) begin : g_mask
    assign maskedCode[b] = inCode[b] & (FILL_W'(b) < effLen);
  end

  always_comb begin
    baseBits = accBits;
    baseFill = fillCnt;
    if (strobe.shiftWord) begin
      baseBits = accBits >> WORD_W;
      baseFill = fillCnt - FILL_W'(WORD_W);
    end else if (strobe.dropPartial) begin
      baseBits = '0;
      baseFill = '0;
    end
    accNext  = baseBits;
    fillNext = baseFill;
    if (strobe.load) begin
      accNext  = baseBits | ({{WORD_W{1'b0}}, maskedCode} << baseFill);
      fillNext = baseFill + effLen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accBits <= '0;
      fillCnt <= '0;
    end else begin
      accBits <= accNext;
      fillCnt <= fillNext;
    end
  end
endmodule

// File: rtl/packCtrl.sv
module packCtrl
  import packPkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic                          flushReq,
  input  logic                          outReady,
  input  logic [$clog2(2*WORD_W+1)-1:0] fillCnt,
  output logic                          inReady,
  output logic                          outValid,
  output ctrlStrobe_t                   strobe
);
  localparam int FILL_W = $clog2(2 * WORD_W + 1);

  logic flushPend, flushPendNext;
  logic fillFull, fillEmpty, outFire;

  assign fillFull  = fillCnt >= FILL_W'(WORD_W);
  assign fillEmpty = fillCnt == '0;
  assign outValid  = fillFull || (flushPend && !fillEmpty);
  assign outFire   = outValid && outReady;
  // room for a full-length code once this cycle's word (if any) has left
  assign inReady   = !flushPend && ((fillCnt <= FILL_W'(WORD_W)) || outReady);

  always_comb begin
    strobe.load        = inValid && inReady;
    strobe.shiftWord   = outFire && fillFull;
    strobe.dropPartial = outFire && !fillFull;
  end

  always_comb begin
    if (flushPend)
      flushPendNext = !(fillEmpty || (outFire && (fillCnt <= FILL_W'(WORD_W))));
    else
      flushPendNext = flushReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flushPend <= 1'b0;
    else       flushPend <= flushPendNext;
  end
endmodule

// File: rtl/bitPacker.sv
module bitPacker
  import packPkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int LEN_W  = DEF_LEN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inCode,
  input  logic [LEN_W-1:0]  inLen,
  input  logic              flushReq,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outWord
);
  localparam int FILL_W = $clog2(2 * WORD_W + 1);

  ctrlStrobe_t          strobe;
  logic [2*WORD_W-1:0]  accBits;
  logic [FILL_W-1:0]    fillCnt;

  packCtrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .flushReq(flushReq),
    .outReady(outReady), .fillCnt(fillCnt), .inReady(inReady),
    .outValid(outValid), .strobe(strobe)
  );

  packData #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inCode(inCode),
    .inLen(inLen), .accBits(accBits), .fillCnt(fillCnt)
  );

  assign outWord = accBits[WORD_W-1:0];
endmodule

// File: rtl/packChecker.sv
module packChecker #(
  parameter int WORD_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          outValid,
  input logic                          outReady,
  input logic [WORD_W-1:0]             outWord,
  input logic                          inReady,
  input logic [2*WORD_W-1:0]           accBits,
  input logic [$clog2(2*WORD_W+1)-1:0] fillCnt
);
  // R3: pending bits never exceed two words
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= 7'(2 * WORD_W));

  // R7: bits above the fill level are zero, so flush words are zero-padded
  a_r7_zero_pad: assert property (@(posedge clk) disable iff (!rstN)
    (accBits >> fillCnt) == '0);

  // R5: an unaccepted word is held
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord)));

  // R6: input is offered only when a full-length code fits
  a_r6_room: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> ((fillCnt <= 7'(WORD_W)) || outReady));
endmodule

bind bitPacker packChecker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .outWord(outWord), .inReady(inReady), .accBits(accBits), .fillCnt(fillCnt)
);

// File: tb/bitPacker_bench.sv
`timescale 1ns/100ps
module bitPacker_bench;
  logic        clk = 0, rstN = 0;
  logic        inValid = 0, flushReq = 0, outReady = 1;
  logic [31:0] inCode = 0;
  logic [5:0]  inLen = 0;
  logic        inReady, outValid;
  logic [31:0] outWord;

  int total = 0, bad = 0;
  bit q[$];
  bit pend = 0, checking = 0, done = 0;
  logic [31:0] got[$];

  always #2.5 clk = ~clk;

  bitPacker u_bitPacker (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCode(inCode), .inLen(inLen), .flushReq(flushReq),
    .outValid(outValid), .outReady(outReady), .outWord(outWord)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", req, what, $time, act, exp);
    end
  endtask

  // reference model: bit queue, compared every clock
  always @(negedge clk) begin
    int pre, eff;
    bit expValid, expReady, outFire, inFire, flushTake;
    logic [31:0] expWord;
    if (rstN && checking) begin
      pre = q.size();
      expValid = pre >= 32;
      expReady = !pend && (pre <= 32 || outReady);
      expWord = 0;
      if (expValid) for (int i = 0; i < 32; i++) expWord[i] = q[i];
      chk(outValid === expValid, "R7", "outValid", 32'(outValid), 32'(expValid));
      chk(inReady === expReady, "R6", "inReady", 32'(inReady), 32'(expReady));
      if (expValid) chk(outWord === expWord, "R2 R5", "outWord", outWord, expWord);
      outFire = expValid && outReady;
      inFire = inValid && expReady;
      flushTake = flushReq && !pend;
      if (outFire) begin
        got.push_back(outWord);
        for (int i = 0; i < 32; i++) void'(q.pop_front());
      end
      if (inFire) begin
        eff = (inLen > 32) ? 32 : int'(inLen);
        for (int i = 0; i < eff; i++) q.push_back(inCode[i]);
      end
      if (flushTake) while (q.size() % 32 != 0) q.push_back(1'b0);
      if (pend) begin
        if (pre == 0 || (outFire && pre == 32)) pend = 0;
      end else pend = flushTake;
    end
  end

  task automatic sendCode(logic [31:0] c, logic [5:0] l);
    @(posedge clk); #1;
    inValid = 1; inCode = c; inLen = l;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk); #1;
    inValid = 0;
  endtask

  task automatic doFlush();
    @(posedge clk); #1 flushReq = 1;
    @(posedge clk); #1 flushReq = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(outValid === 1'b0, "R1", "reset outValid", 32'(outValid), 0);
    chk(inReady === 1'b1, "R1", "reset inReady", 32'(inReady), 1);
    checking = 1;

    // R2: short codes packed from bit 0 upward
    got.delete();
    sendCode(32'h5, 3); sendCode(32'h1, 1); sendCode(32'h3, 2);
    doFlush(); idle(4);
    chk(got.size() == 1, "R2", "word count", got.size(), 1);
    if (got.size() > 0) chk(got[0] == 32'h3D, "R2", "packed word", got[0], 32'h3D);

    // R3: split code continues at bit 0 of next word
    got.delete();
    sendCode(32'hABCDE, 20); sendCode(32'h12345, 20);
    doFlush(); idle(4);
    chk(got.size() == 2, "R3", "word count", got.size(), 2);
    if (got.size() == 2) begin
      chk(got[0] == 32'h345ABCDE, "R3", "first word", got[0], 32'h345ABCDE);
      chk(got[1] == 32'h00000012, "R3", "split tail", got[1], 32'h12);
    end

    // R4: upper code bits ignored, zero length adds nothing, long length saturates
    got.delete();
    sendCode(32'hFFFFFFFF, 4); sendCode(32'hFFFFFFFF, 0);
    doFlush(); idle(4);
    chk(got.size() == 1, "R4", "word count", got.size(), 1);
    if (got.size() > 0) chk(got[0] == 32'hF, "R4", "masked word", got[0], 32'hF);
    got.delete();
    sendCode(32'hA5A5A5A5, 6'd40);
    doFlush(); idle(4);
    chk(got.size() == 1, "R4", "saturated count", got.size(), 1);
    if (got.size() > 0) chk(got[0] == 32'hA5A5A5A5, "R4", "saturated word", got[0], 32'hA5A5A5A5);

    // R8: flush on empty, repeated flush while pending
    got.delete();
    doFlush(); idle(3);
    @(posedge clk); #1 flushReq = 1; idle(2); flushReq = 0; idle(3);
    chk(got.size() == 0, "R8", "empty flush words", got.size(), 0);

    // R7: next block starts word-aligned
    got.delete();
    sendCode(32'h7, 3); doFlush(); sendCode(32'h1, 1); doFlush(); idle(4);
    chk(got.size() == 2, "R7", "word count", got.size(), 2);
    if (got.size() == 2) begin
      chk(got[0] == 32'h7, "R7", "first block", got[0], 32'h7);
      chk(got[1] == 32'h1, "R7", "second block", got[1], 32'h1);
    end

    // R5 R6: back-pressure with a full accumulator
    got.delete();
    outReady = 0;
    sendCode(32'h11112222, 32); sendCode(32'h33334444, 32);
    chk(inReady === 1'b0, "R6", "full inReady", 32'(inReady), 0);
    idle(3);
    chk(outWord === 32'h11112222, "R5", "held word", outWord, 32'h11112222);
    outReady = 1; idle(4);
    chk(got.size() == 2, "R5", "drained count", got.size(), 2);
    if (got.size() == 2) chk(got[1] == 32'h33334444, "R5", "second word", got[1], 32'h33334444);

    // random phase: overlapping accept, emit and flush
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #1;
      inValid  = ($urandom_range(0, 7) != 0);
      inCode   = $urandom;
      inLen    = 6'($urandom_range(0, 40));
      flushReq = ($urandom_range(0, 15) == 0);
      outReady = ($urandom_range(0, 3) != 0);
    end
    @(posedge clk); #1;
    inValid = 0; flushReq = 0; outReady = 1;
    doFlush(); idle(20);
    chk(q.size() == 0, "R7", "drained after flush", q.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule